// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit control and status word that remembers why the system last came out of reset. Software can also use it to ask for a new reset. The word sits in an 8-byte window. Only the upper word, the one with address bit 2 set, is live. The lower word reads as zero and discards writes.

Five bits are defined, all at the top of the word:

| Bit | Meaning | How it is set | How it is cleared |
|-----|---------|---------------|-------------------|
| 31 | First power-up | Loaded at the first system reset | Write one to clear |
| 30 | Soft power-up request | Write one to set | Reload at the next first system reset |
| 29 | Soft warm-reset request | Write one to set | Reload at the next first system reset |
| 28 | Button power-up | Pulse on `btn_cold_i` | Write one to clear |
| 27 | Button warm reset | Pulse on `btn_warm_i` | Write one to clear |

The block keeps a saturating count of system resets seen since power-up. When that count is zero, the next system reset loads the word with only bit 31 set. Later system resets leave the word unchanged. Software can start a fresh power-up sequence by setting bit 30. That write clears the counter and pulses the reset request output. Setting bit 29 only pulses the request output.

All pins are plain control and status pins. A write takes effect on the clock edge where `wr_en_i` is high, with no handshake and no back-pressure. Read data is combinational from `addr_i`.

Top module: `reset_cause_reg`

## Requirements
- R1: After `pwr_rst_ni` is released, reads of both words return 0 and `sys_reset_req_o` is 0. The reset counter starts at zero.
- R2: A read with address bit 2 set returns the five cause bits at positions 31..27, with bits 26..0 zero. A read with address bit 2 clear returns 0.
- R3: A write with address bit 2 clear changes no bit and raises no reset request.
- R4: Bits 31, 28 and 27 clear when a one is written to them. Writing zero to them leaves them unchanged.
- R5: Bits 30 and 29 set when a one is written to them. Writing zero to them never clears them.
- R6: Writing one to bit 30 clears the reset counter and raises a request, so the next system reset loads 0x80000000.
- R7: Writing one to bit 29 raises a request but does not clear the counter. A later system reset then keeps the word's contents.
- R8: The first system reset after power-up sets the word to exactly 0x80000000. Any later system reset leaves the word unchanged.
- R9: A one-cycle pulse on `btn_cold_i` sets bit 28, and a pulse on `btn_warm_i` sets bit 27. A button set wins over a write-one-to-clear of the same bit in the same cycle.
- R10: The reset counter saturates at its maximum. No number of system resets can make it look zero again and reload bit 31.
- R11: When `sys_rst_i` and `wr_en_i` are high in the same cycle, the write is discarded: no bit changes from it and no request is raised.
- R12: `sys_reset_req_o` is high for exactly one cycle, the cycle after the accepted write that requested it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| pwr_rst_ni | input | 1 | Asynchronous power-up reset, active low |
| sys_rst_i | input | 1 | System reset event, one cycle per reset |
| btn_cold_i | input | 1 | Button power-up cause pulse |
| btn_warm_i | input | 1 | Button warm-reset cause pulse |
| addr_i | input | 3 | Byte offset within the 8-byte window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Writes are driven with all-ones, all-zeros, single-bit patterns and low-half-only data, to both words of the window. This separates the write-one-to-clear bits from the write-one-to-set bits, and shows both the input mask and the word select. System resets are issued after power-up, after a soft warm request and after a soft power-up request. Only the counter state should decide whether bit 31 is reloaded. A run of resets longer than the counter range shows the difference between saturation and wrap-around. Same-cycle collisions, button against clear and system reset against write, fix the stated priorities.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CAUSE_N = 5;
  localparam int unsigned CAUSE_LSB = WORD_W - CAUSE_N;   // 27

  // index inside the 5-bit cause vector (vector bit i sits at word bit 27+i)
  localparam int unsigned IDX_BTN_WARM = 0;
  localparam int unsigned IDX_BTN_COLD = 1;
  localparam int unsigned IDX_SOFT_WARM = 2;
  localparam int unsigned IDX_SOFT_COLD = 3;
  localparam int unsigned IDX_POWER_UP  = 4;

  localparam logic [CAUSE_N-1:0] CLR1_MASK = 5'b10011;
  localparam logic [CAUSE_N-1:0] SET1_MASK = 5'b01100;
  localparam logic [CAUSE_N-1:0] POWER_UP_ONLY = 5'b10000;
endpackage

// File: rtl/rc_boot_counter.sv
module rc_boot_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk_i,
  input  logic pwr_rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  output logic first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge pwr_rst_ni) begin
    if (!pwr_rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
    end
  end

  assign first_o = (cnt_q == '0);

  a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
  a_r6_clear_arms: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    (clr_i && !inc_i) |=> first_o);
endmodule

// File: rtl/rc_cause_bits.sv
module rc_cause_bits
  import reset_cause_pkg::*;
(
  input  logic               clk_i,
  input  logic               pwr_rst_ni,
  input  logic               sys_rst_i,
  input  logic               first_i,
  input  logic               wr_fire_i,
  input  logic [CAUSE_N-1:0] wr_bits_i,
  input  logic               btn_cold_i,
  input  logic               btn_warm_i,
  output logic [CAUSE_N-1:0] cause_o
);
  logic [CAUSE_N-1:0] cause_q, cause_d, btn_set;

  always_comb begin
    btn_set = '0;
    btn_set[IDX_BTN_COLD] = btn_cold_i;
    btn_set[IDX_BTN_WARM] = btn_warm_i;
    cause_d = cause_q;
    if (sys_rst_i) begin
      if (first_i) cause_d = POWER_UP_ONLY;
    end else if (wr_fire_i) begin
      cause_d = (cause_q & ~(wr_bits_i & CLR1_MASK)) | (wr_bits_i & SET1_MASK);
    end
    cause_d = cause_d | btn_set;
  end

  always_ff @(posedge clk_i or negedge pwr_rst_ni) begin
    if (!pwr_rst_ni) cause_q <= '0;
    else             cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  a_r4_clear_on_one: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    (wr_fire_i && !sys_rst_i && wr_bits_i[IDX_POWER_UP]) |=> !cause_q[IDX_POWER_UP]);
  a_r5_sticky_set: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    (cause_q[IDX_SOFT_WARM] && !sys_rst_i) |=> cause_q[IDX_SOFT_WARM]);
  a_r8_first_load: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    (sys_rst_i && first_i && !btn_cold_i && !btn_warm_i) |=> (cause_q == POWER_UP_ONLY));
  a_r9_button_wins: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    btn_cold_i |=> cause_q[IDX_BTN_COLD]);
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import reset_cause_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEL_BIT = 2,
  parameter int unsigned CNT_W   = 2
) (
  input  logic              clk_i,
  input  logic              pwr_rst_ni,
  input  logic              sys_rst_i,
  input  logic              btn_cold_i,
  input  logic              btn_warm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              sys_reset_req_o
);
  logic               live_word, wr_fire, first, req_q;
  logic [CAUSE_N-1:0] wr_bits, cause;

  assign live_word = addr_i[SEL_BIT];
  assign wr_fire   = wr_en_i && live_word && !sys_rst_i;
  assign wr_bits   = wr_data_i[WORD_W-1:CAUSE_LSB];

  rc_boot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .pwr_rst_ni (pwr_rst_ni),
    .inc_i      (sys_rst_i),
    .clr_i      (wr_fire && wr_bits[IDX_SOFT_COLD]),
    .first_o    (first)
  );

  rc_cause_bits u_bits (
    .clk_i      (clk_i),
    .pwr_rst_ni (pwr_rst_ni),
    .sys_rst_i  (sys_rst_i),
    .first_i    (first),
    .wr_fire_i  (wr_fire),
    .wr_bits_i  (wr_bits),
    .btn_cold_i (btn_cold_i),
    .btn_warm_i (btn_warm_i),
    .cause_o    (cause)
  );

  always_ff @(posedge clk_i or negedge pwr_rst_ni) begin
    if (!pwr_rst_ni) req_q <= 1'b0;
    else req_q <= wr_fire && (wr_bits[IDX_SOFT_COLD] || wr_bits[IDX_SOFT_WARM]);
  end

  assign sys_reset_req_o = req_q;
  assign rd_data_o = live_word ? {cause, {CAUSE_LSB{1'b0}}} : '0;

  a_r12_req_after_write: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    sys_reset_req_o |-> $past(wr_en_i && !sys_rst_i));
  a_r11_reset_blocks_req: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    sys_rst_i |=> !sys_reset_req_o);
  a_r3_dead_word_quiet: assert property (@(posedge clk_i) disable iff (!pwr_rst_ni)
    (wr_en_i && !addr_i[SEL_BIT] && !sys_rst_i && !btn_cold_i && !btn_warm_i)
      |=> ($stable(cause) && !sys_reset_req_o));
endmodule

// File: tb/reset_cause_reg_tb.sv
module reset_cause_reg_tb;
  logic        clk = 1'b0;
  logic        pwr_rst_n = 1'b0;
  logic        sys_rst = 1'b0, btn_cold = 1'b0, btn_warm = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reset_cause_reg u_dut (
    .clk_i(clk), .pwr_rst_ni(pwr_rst_n), .sys_rst_i(sys_rst),
    .btn_cold_i(btn_cold), .btn_warm_i(btn_warm), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .sys_reset_req_o(req)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req_tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rd_data, exp);
    addr = 3'd4;
  endtask

  // drive one cycle of stimulus at negedge, returns at next negedge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic sr, input logic bc, input logic bw);
    wr_en = we; addr = a; wr_data = d; sys_rst = sr; btn_cold = bc; btn_warm = bw;
    @(negedge clk);
    wr_en = 0; addr = 3'd4; wr_data = '0; sys_rst = 0; btn_cold = 0; btn_warm = 0;
  endtask

  task automatic t_reset;
    read_chk("R1", 3'd4, 32'h0);
    read_chk("R1", 3'd0, 32'h0);
    chk("R1", {31'b0, req}, 32'h0);
  endtask

  task automatic t_first_reset;
    cyc(0, 4, 0, 1, 0, 0);
    read_chk("R8", 3'd4, 32'h8000_0000);
    read_chk("R2", 3'd0, 32'h0);
  endtask

  task automatic t_dead_word;
    cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R3", {31'b0, req}, 32'h0);
    read_chk("R3", 3'd4, 32'h8000_0000);
  endtask

  task automatic t_w1c;
    cyc(1, 4, 32'h0, 0, 0, 0);
    read_chk("R4", 3'd4, 32'h8000_0000);
    cyc(1, 4, 32'h8000_0000, 0, 0, 0);
    read_chk("R4", 3'd4, 32'h0);
  endtask

  task automatic t_buttons;
    cyc(0, 4, 0, 0, 1, 0);
    read_chk("R9", 3'd4, 32'h1000_0000);
    cyc(1, 4, 32'h0800_0000, 0, 0, 1);
    read_chk("R9", 3'd4, 32'h1800_0000);
    cyc(1, 4, 32'h1800_0000, 0, 0, 0);
    read_chk("R4", 3'd4, 32'h0);
  endtask

  task automatic t_soft_warm;
    cyc(1, 4, 32'h2000_0000, 0, 0, 0);
    chk("R12", {31'b0, req}, 32'h1);
    @(negedge clk);
    chk("R12", {31'b0, req}, 32'h0);
    read_chk("R5", 3'd4, 32'h2000_0000);
    cyc(1, 4, 32'h0000_FFFF, 0, 0, 0);
    read_chk("R2", 3'd4, 32'h2000_0000);
    cyc(1, 4, 32'h0, 0, 0, 0);
    read_chk("R5", 3'd4, 32'h2000_0000);
    cyc(0, 4, 0, 1, 0, 0);
    read_chk("R7", 3'd4, 32'h2000_0000);
  endtask

  task automatic t_soft_cold;
    cyc(1, 4, 32'h4000_0000, 0, 0, 0);
    chk("R6", {31'b0, req}, 32'h1);
    read_chk("R5", 3'd4, 32'h6000_0000);
    @(negedge clk);
    cyc(0, 4, 0, 1, 0, 0);
    read_chk("R6", 3'd4, 32'h8000_0000);
  endtask

  task automatic t_collide;
    cyc(1, 4, 32'hC000_0000, 1, 0, 0);
    chk("R11", {31'b0, req}, 32'h0);
    read_chk("R11", 3'd4, 32'h8000_0000);
  endtask

  task automatic t_saturate;
    cyc(1, 4, 32'h8000_0000, 0, 0, 0);
    read_chk("R10", 3'd4, 32'h0);
    for (int i = 0; i < 6; i++) cyc(0, 4, 0, 1, 0, 0);
    read_chk("R10", 3'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_reset();
    t_dead_word();
    t_w1c();
    t_buttons();
    t_soft_warm();
    t_soft_cold();
    t_collide();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule